// File: doc/BRIEF.md
# Multi-bit independent clock-domain synchronizer

This block moves a group of unrelated one-bit signals, such as status flags, enables or level requests, from one clock domain into another, unrelated one. Each bit is first registered on the source clock. The registered value then crosses into the destination domain through its own chain of destination-clocked flip-flops. The output is the last flop of each chain.

Each bit crosses on its own. After one source-side change, two bits may first show their new values in different destination cycles. The block therefore suits flags and levels. It does not suit counters, addresses or any other value whose bits must change together.

The source-side register keeps combinational logic in the source domain from feeding the first destination flop. Each side has its own active-high synchronous reset. The vector width and the destination chain depth are parameters. The depth must be between 2 and 4, and any other value stops elaboration with an error.

Top module: `multibit_sync`

## Requirements
- R1: While the destination reset is sampled high, every output bit reads 0 from the next destination clock edge onward. This holds whatever the input vector is.
- R2: A source input change held across a source clock rising edge is captured at that edge. It appears on the output at exactly the STAGES-th destination rising edge after the capture edge, and not at any earlier edge.
- R3: Each bit has its own independent path. Changing one input bit never disturbs the output value of any other bit.
- R4: The source reset, sampled high on a source clock edge, clears the source capture register to 0. While it stays asserted, the output falls to all zeros STAGES destination edges later, even if the input is held at all ones and the destination reset stays low.
- R5: The destination reset clears every destination stage at the edge where it is sampled. After it is released, the output stays 0 for the next STAGES-1 destination edges and shows the captured source value at the STAGES-th edge.
- R6: An input pulse that begins and ends between two source rising edges is never captured. The output does not change in response to it.
- R7: The latency in destination edges equals the STAGES parameter. STAGES defaults to 2 and WIDTH defaults to 1. A STAGES value outside 2 to 4 is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source-domain clock |
| src_rst | input | 1 | Active-high synchronous reset of the source capture register |
| src_bits | input | WIDTH | Independent input bits, synchronous to src_clk |
| dst_clk | input | 1 | Destination-domain clock |
| dst_rst | input | 1 | Active-high synchronous reset of all destination stages |
| dst_bits | output | WIDTH | Synchronized output bits, synchronous to dst_clk |

## Verification
Every new output value is due a fixed number of edges after its cause:
- An input change is due at the STAGES-th destination edge after the source edge that captures it.
- After the destination reset is released, the captured value is due at the STAGES-th edge.

The clock periods are chosen so that no source edge ever coincides with a destination edge. The bench therefore waits for the capture edge and then counts destination edges. It samples one nanosecond after each counted edge and confirms the old value at the first STAGES-1 edges and the new value at the STAGES-th. Checks that a glitch or a change on another bit has no effect sample the output at every destination edge over a window longer than the full latency.

// File: rtl/multibit_sync_pkg.sv
package multibit_sync_pkg;

   localparam int unsigned SYNC_MIN_STAGES = 2;
   localparam int unsigned SYNC_MAX_STAGES = 4;

   function automatic bit stages_in_range(input int unsigned n);
      return (n >= SYNC_MIN_STAGES) && (n <= SYNC_MAX_STAGES);
   endfunction

endpackage

// File: rtl/multibit_sync_capture.sv
module multibit_sync_capture #(
   parameter int unsigned WIDTH = 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   always_ff @(posedge clk) begin
      if (rst) begin
         q <= '0;
      end else begin
         q <= d;
      end
   end

endmodule

// File: rtl/multibit_sync_chain.sv
module multibit_sync_chain #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic d,
   output logic q
);

   localparam int unsigned LAST = STAGES - 1;

   logic stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_head
         always_ff @(posedge clk) begin
            if (rst) begin
               stg[0] <= 1'b0;
            end else begin
               stg[0] <= d;
            end
         end
      end else begin : g_tail
         always_ff @(posedge clk) begin
            if (rst) begin
               stg[s] <= 1'b0;
            end else begin
               stg[s] <= stg[s-1];
            end
         end
      end
   end

   assign q = stg[LAST];

endmodule

// File: rtl/multibit_sync.sv
module multibit_sync
   import multibit_sync_pkg::*;
#(
   parameter int unsigned WIDTH  = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic             src_clk,
   input  logic             src_rst,
   input  logic [WIDTH-1:0] src_bits,
   input  logic             dst_clk,
   input  logic             dst_rst,
   output logic [WIDTH-1:0] dst_bits
);

   if (!stages_in_range(STAGES)) begin : g_bad_stages
      $error("multibit_sync: STAGES=%0d outside allowed range %0d..%0d",
             STAGES, SYNC_MIN_STAGES, SYNC_MAX_STAGES);
   end

   if (WIDTH < 1) begin : g_bad_width
      $error("multibit_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] src_q;

   multibit_sync_capture #(
      .WIDTH (WIDTH)
   ) u_capture (
      .clk (src_clk),
      .rst (src_rst),
      .d   (src_bits),
      .q   (src_q)
   );

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      multibit_sync_chain #(
         .STAGES (STAGES)
      ) u_chain (
         .clk (dst_clk),
         .rst (dst_rst),
         .d   (src_q[b]),
         .q   (dst_bits[b])
      );
   end

endmodule

// File: rtl/multibit_sync_chk.sv
module multibit_sync_chk #(
   parameter int unsigned WIDTH  = 1,
   parameter int unsigned STAGES = 2
) (
   input logic             src_clk,
   input logic             src_rst,
   input logic [WIDTH-1:0] src_bits,
   input logic [WIDTH-1:0] src_q,
   input logic             dst_clk,
   input logic             dst_rst,
   input logic [WIDTH-1:0] dst_bits
);

   logic       src_armed;
   logic [2:0] dst_age;

   always_ff @(posedge src_clk) begin
      if (src_rst) src_armed <= 1'b1;
   end

   always_ff @(posedge dst_clk) begin
      if (dst_rst) begin
         dst_age <= '0;
      end else if (dst_age < 3'(STAGES)) begin
         dst_age <= dst_age + 3'd1;
      end
   end

   // R1: destination reset clears the output
   assert_rst_clear_R1: assert property (@(posedge dst_clk)
      dst_rst |=> (dst_bits == '0));

   // R2: output is the source register as sampled STAGES destination edges ago
   assert_latency_R2: assert property (@(posedge dst_clk) disable iff (dst_rst)
      (dst_age == 3'(STAGES)) |-> (dst_bits == $past(src_q, STAGES)));

   // R4: source reset clears the capture register
   assert_src_clear_R4: assert property (@(posedge src_clk)
      src_rst |=> (src_q == '0));

   // R6: capture register follows only the value sampled at a source edge
   assert_capture_R6: assert property (@(posedge src_clk) disable iff (src_rst)
      (src_armed && !$past(src_rst)) |-> (src_q == $past(src_bits)));

endmodule

bind multibit_sync multibit_sync_chk #(
   .WIDTH  (WIDTH),
   .STAGES (STAGES)
) u_chk (
   .src_clk  (src_clk),
   .src_rst  (src_rst),
   .src_bits (src_bits),
   .src_q    (src_q),
   .dst_clk  (dst_clk),
   .dst_rst  (dst_rst),
   .dst_bits (dst_bits)
);

// File: tb/sim_multibit_sync.sv
`timescale 1ns/100ps
module sim_multibit_sync;

   localparam int unsigned W0 = 4;
   localparam int unsigned S0 = 3;
   localparam int unsigned S1 = 2;

   logic       src_clk, dst_clk, src_rst, dst_rst;
   logic [3:0] in0, out0;
   logic       in1, out1;
   int         total = 0;
   int         fails = 0;
   bit         done  = 0;

   multibit_sync #(.WIDTH(W0), .STAGES(S0)) u0 (
      .src_clk (src_clk), .src_rst (src_rst), .src_bits (in0),
      .dst_clk (dst_clk), .dst_rst (dst_rst), .dst_bits (out0)
   );

   // default parameters: WIDTH 1, STAGES 2 (R7)
   multibit_sync u1 (
      .src_clk (src_clk), .src_rst (src_rst), .src_bits (in1),
      .dst_clk (dst_clk), .dst_rst (dst_rst), .dst_bits (out1)
   );

   // 125 MHz source; destination 13 ns, offset so edges never coincide
   initial begin
      src_clk = 1'b0;
      forever #4 src_clk = ~src_clk;
   end
   initial begin
      dst_clk = 1'b0;
      #1;
      forever #6.5 dst_clk = ~dst_clk;
   end

   task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [3:0] rd(input bit inst);
      return inst ? {3'b000, out1} : out0;
   endfunction

   task automatic settle();
      repeat (6) @(posedge dst_clk);
      #1;
   endtask

   task automatic t_reset();
      src_rst = 1'b1; dst_rst = 1'b1;
      in0 = 4'hF; in1 = 1'b1;
      repeat (4) @(posedge dst_clk);
      #1;
      chk("R1 reset u0", out0, 4'h0);
      chk("R1 reset u1", rd(1'b1), 4'h0);
      @(negedge src_clk);
      in0 = 4'h0; in1 = 1'b0;
      src_rst = 1'b0;
      @(negedge dst_clk);
      dst_rst = 1'b0;
      settle();
      chk("R1 after release", out0, 4'h0);
   endtask

   task automatic t_latency(input bit inst, input logic [3:0] v, input string req);
      int unsigned stages = inst ? S1 : S0;
      logic [3:0] old = rd(inst);
      logic [3:0] nv  = inst ? {3'b000, v[0]} : v;
      @(negedge src_clk);
      if (inst) in1 = v[0];
      else      in0 = v;
      @(posedge src_clk);
      for (int i = 1; i < int'(stages); i++) begin
         @(posedge dst_clk);
         #1;
         chk({req, " early"}, rd(inst), old);
      end
      @(posedge dst_clk);
      #1;
      chk({req, " due"}, rd(inst), nv);
      settle();
   endtask

   task automatic t_independent();
      logic [3:0] old = out0;
      @(negedge src_clk);
      in0 = old ^ 4'b0100;
      for (int i = 0; i < int'(S0) + 2; i++) begin
         @(posedge dst_clk);
         #1;
         chk("R3 other bits steady", out0 & 4'b1011, old & 4'b1011);
      end
      chk("R3 toggled bit", out0, old ^ 4'b0100);
      settle();
   endtask

   task automatic t_glitch();
      logic [3:0] old = out0;
      @(negedge src_clk);
      #1 in0 = old ^ 4'b0010;
      #2 in0 = old;
      for (int i = 0; i < int'(S0) + 3; i++) begin
         @(posedge dst_clk);
         #1;
         chk("R6 glitch ignored", out0, old);
      end
   endtask

   task automatic t_src_reset();
      @(negedge src_clk);
      in0 = 4'hF;
      settle();
      chk("R4 preset ones", out0, 4'hF);
      @(negedge src_clk);
      src_rst = 1'b1;
      @(posedge src_clk);
      repeat (S0) @(posedge dst_clk);
      #1;
      chk("R4 source reset clears", out0, 4'h0);
      repeat (2) @(negedge src_clk);
      src_rst = 1'b0;
      settle();
      chk("R4 refilled after release", out0, 4'hF);
   endtask

   task automatic t_dst_reset();
      @(negedge dst_clk);
      dst_rst = 1'b1;
      @(posedge dst_clk);
      #1;
      chk("R5 cleared at edge", out0, 4'h0);
      @(negedge dst_clk);
      dst_rst = 1'b0;
      for (int i = 1; i < int'(S0); i++) begin
         @(posedge dst_clk);
         #1;
         chk("R5 still refilling", out0, 4'h0);
      end
      @(posedge dst_clk);
      #1;
      chk("R5 refilled", out0, 4'hF);
      settle();
   endtask

   initial begin
      t_reset();
      t_latency(1'b0, 4'b1010, "R2 0->A");
      t_latency(1'b0, 4'b0101, "R2 A->5");
      t_latency(1'b0, 4'b1111, "R2 5->F");
      t_latency(1'b0, 4'b0000, "R2 F->0");
      t_independent();
      t_glitch();
      t_latency(1'b1, 4'b0001, "R7 default depth rise");
      t_latency(1'b1, 4'b0000, "R7 default depth fall");
      t_src_reset();
      t_dst_reset();
      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         total++;
         fails++;
         $display("FAIL R2 watchdog actual=timeout expected=completion");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

endmodule